// File: doc/BRIEF.md
# Circuit Liveness Monitor

This block watches the health of a single virtual circuit. It sends end-to-end loopback probes on a schedule that a one-second tick drives, and it watches for the matching replies. It declares the circuit up or down only after a configurable run of consecutive answered or unanswered probes. A single miss or a single reply never flips the state.

While the state is settled, probes go out at a slow normal interval. As soon as the evidence starts to point the other way, the block moves to a faster retry interval. A miss while up, or a reply while down, does this. The fast interval lets the decision be confirmed or dropped quickly, and the normal interval returns once the question is settled. The block does not build cells, match reply tags or react to routing. It only produces a probe request pulse and the circuit state.

Top module: `vc_liveness_monitor`

## Requirements
- R1: While down, the circuit goes up (`circuit_up` = 1) only once `cfg_up_count` consecutive probes have been answered. The change appears at the clock edge that evaluates the last of these probes.
- R2: While up, the circuit goes down (`circuit_up` = 0) only once `cfg_down_count` consecutive probes have gone unanswered. The change appears at the clock edge that evaluates the last of these probes.
- R3: In the settled state, a probe is issued on every `cfg_normal_period`-th tick.
- R4: While a change of state is being verified (up with at least one miss, or down with at least one reply), a probe is issued on every `cfg_retry_period`-th tick.
- R5: When verification ends in either direction, the next probe is due `cfg_normal_period` ticks after the one that ended it.
- R6: A reply counts for the outstanding probe if it arrives no later than the cycle in which the next probe falls due, that same cycle included. Otherwise the probe counts as missed.
- R7: Any answered probe clears the run of misses. Any missed probe clears the run of answers.
- R8: While `enable` is 0, no probe is issued, replies are ignored and `circuit_up` holds its value.
- R9: After reset, and in the cycle in which `enable` rises, the state becomes up with both runs cleared. The first probe then follows `cfg_normal_period` ticks later.
- R10: `probe_send` is a registered pulse. It is high in the cycle after the tick that made the probe due. Zero thresholds and zero periods behave as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Probing enable; 0 after reset by the integrator |
| sec_tick | input | 1 | One-cycle pulse per second |
| reply_rx | input | 1 | One-cycle pulse: loopback reply received |
| cfg_up_count | input | CNT_W | Consecutive answers needed to declare up |
| cfg_down_count | input | CNT_W | Consecutive misses needed to declare down |
| cfg_normal_period | input | PER_W | Probe interval in ticks when settled |
| cfg_retry_period | input | PER_W | Probe interval in ticks while verifying |
| probe_send | output | 1 | One-cycle request to send a loopback probe |
| circuit_up | output | 1 | 1 = circuit up, 0 = circuit down |

## Verification
The bench drives the monitor through a miss followed by a reply while up, and through an answer followed by a miss while down. A design that did not clear the opposing run would then reach a decision too early or too late. It checks that the probe right after a first miss comes one tick later rather than four, and that the normal spacing returns right after each decision. A design that kept the wrong period would show probes in the wrong cycles. Replies that arrive in the very cycle the next probe falls due are counted. A design with an off-by-one deadline would record a miss there. Finally, the circuit is taken down and disabled while ticks and replies keep arriving, and then re-enabled. A design that kept working while disabled, or did not restart as up, would be caught.

// File: rtl/vc_live_pkg.sv
// Package: shared helpers for the circuit liveness monitor.
// Assumes: configuration values are unsigned counts.
package vc_live_pkg;

    // Treat a zero count as one, so that a zero setting never stalls the block.
    function automatic logic [15:0] at_least_one(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction

endpackage

// File: rtl/lvm_probe_timer.sv
// Module: lvm_probe_timer
// Counts one-second ticks and marks a probe as due once the selected period
// has elapsed. It also registers the probe request pulse.
// Assumes: tick is a single-cycle pulse; period may change at any time, and a
// shorter period takes effect on the next tick.
module lvm_probe_timer
    import vc_live_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             due,
    output logic             probe_send
);
    localparam int EXT_W = 16;

    logic [PER_W-1:0] sec_cnt;
    logic [EXT_W-1:0] eff_period;

    // Effective period (zero behaves as one) and the due condition.
    always_comb begin
        eff_period = at_least_one(EXT_W'(period));
        due = active && !restart && tick &&
              (EXT_W'(sec_cnt) >= (eff_period - EXT_W'(1)));
    end

    // Tick counter and registered probe pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_cnt    <= '0;
            probe_send <= 1'b0;
        end else begin
            probe_send <= due;
            if (!active || restart) begin
                sec_cnt <= '0;
            end else if (tick) begin
                sec_cnt <= due ? '0 : sec_cnt + PER_W'(1);
            end
        end
    end

endmodule

// File: rtl/lvm_verdict.sv
// Module: lvm_verdict
// Tracks the outstanding probe, judges it answered or missed when the next
// probe falls due, keeps the runs of answers and misses, and decides the
// circuit state. It also reports whether a state change is being verified.
// Assumes: due and reply are single-cycle pulses; restart is a single cycle.
module lvm_verdict
    import vc_live_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic             due,
    input  logic             reply,
    input  logic [CNT_W-1:0] up_count,
    input  logic [CNT_W-1:0] down_count,
    output logic             circuit_up,
    output logic             verifying
);
    localparam int EXT_W = 16;

    logic [CNT_W-1:0] ok_run;
    logic [CNT_W-1:0] miss_run;
    logic             pending;
    logic             answered;
    logic             answered_now;
    logic [EXT_W-1:0] up_eff;
    logic [EXT_W-1:0] down_eff;
    logic [EXT_W-1:0] ok_next;
    logic [EXT_W-1:0] miss_next;

    // Helper values for the judgement made at the due point.
    always_comb begin
        answered_now = answered || reply;
        up_eff       = at_least_one(EXT_W'(up_count));
        down_eff     = at_least_one(EXT_W'(down_count));
        ok_next      = EXT_W'(ok_run) + EXT_W'(1);
        miss_next    = EXT_W'(miss_run) + EXT_W'(1);
        verifying    = circuit_up ? (miss_run != '0) : (ok_run != '0);
    end

    // Probe bookkeeping, runs and the up/down decision.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            circuit_up <= 1'b1;
            ok_run     <= '0;
            miss_run   <= '0;
            pending    <= 1'b0;
            answered   <= 1'b0;
        end else if (active) begin
            if (due) begin
                pending  <= 1'b1;
                answered <= 1'b0;
                if (pending) begin
                    if (answered_now) begin
                        miss_run <= '0;
                        if (!circuit_up) begin
                            if (ok_next >= up_eff) begin
                                circuit_up <= 1'b1;
                                ok_run     <= '0;
                            end else begin
                                ok_run <= ok_next[CNT_W-1:0];
                            end
                        end
                    end else begin
                        ok_run <= '0;
                        if (circuit_up) begin
                            if (miss_next >= down_eff) begin
                                circuit_up <= 1'b0;
                                miss_run   <= '0;
                            end else begin
                                miss_run <= miss_next[CNT_W-1:0];
                            end
                        end
                    end
                end
            end else if (reply && pending) begin
                answered <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vc_liveness_monitor.sv
// Module: vc_liveness_monitor (top)
// Liveness monitor for one virtual circuit: schedules loopback probes on a
// one-second tick, counts replies and declares the circuit up or down.
// Assumes: sec_tick and reply_rx are single-cycle pulses in the clk domain.
module vc_liveness_monitor #(
    parameter int CNT_W = 8,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sec_tick,
    input  logic             reply_rx,
    input  logic [CNT_W-1:0] cfg_up_count,
    input  logic [CNT_W-1:0] cfg_down_count,
    input  logic [PER_W-1:0] cfg_normal_period,
    input  logic [PER_W-1:0] cfg_retry_period,
    output logic             probe_send,
    output logic             circuit_up
);
    logic             enable_q;
    logic             restart;
    logic             due;
    logic             verifying;
    logic [PER_W-1:0] period_sel;

    // Remember the previous enable so that a rising edge restarts the block.
    always_ff @(posedge clk) begin
        if (!rst_n) enable_q <= 1'b0;
        else        enable_q <= enable;
    end

    // Restart pulse and choice of the active probe period.
    always_comb begin
        restart    = enable && !enable_q;
        period_sel = verifying ? cfg_retry_period : cfg_normal_period;
    end

    lvm_probe_timer #(.PER_W(PER_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (enable),
        .restart    (restart),
        .tick       (sec_tick),
        .period     (period_sel),
        .due        (due),
        .probe_send (probe_send)
    );

    lvm_verdict #(.CNT_W(CNT_W)) i_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (enable),
        .restart    (restart),
        .due        (due),
        .reply      (reply_rx),
        .up_count   (cfg_up_count),
        .down_count (cfg_down_count),
        .circuit_up (circuit_up),
        .verifying  (verifying)
    );

endmodule

// File: rtl/lvm_checker.sv
// Module: lvm_checker
// Temporal checks on the monitor ports, attached to every instance by bind.
module lvm_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sec_tick,
    input logic probe_send,
    input logic circuit_up
);
    // R10: a probe only follows an enabled tick one cycle earlier.
    p_probe_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        probe_send |-> ($past(sec_tick) && $past(enable)));

    // R8: state is held across a disabled cycle.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(circuit_up));

    // R9: enabling starts the circuit in the up state.
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> circuit_up);

    // R2: a down decision coincides with a probe being issued.
    p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(circuit_up) |-> probe_send);

    // R1: going up needs an enabled due tick or an enable restart.
    p_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(circuit_up) |-> ($past(enable) && ($past(sec_tick) || !$past(enable, 2))));
endmodule

bind vc_liveness_monitor lvm_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sec_tick   (sec_tick),
    .probe_send (probe_send),
    .circuit_up (circuit_up)
);

// File: tb/test_vc_liveness_monitor.sv
module test_vc_liveness_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       sec_tick = 1'b0;
    logic       reply_rx = 1'b0;
    logic [7:0] cfg_up_count = 8'd3;
    logic [7:0] cfg_down_count = 8'd2;
    logic [7:0] cfg_normal_period = 8'd4;
    logic [7:0] cfg_retry_period = 8'd1;
    logic       probe_send;
    logic       circuit_up;

    typedef struct {
        bit    probe;
        bit    up;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    vc_liveness_monitor i_vc_liveness_monitor (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sec_tick(sec_tick),
        .reply_rx(reply_rx), .cfg_up_count(cfg_up_count),
        .cfg_down_count(cfg_down_count), .cfg_normal_period(cfg_normal_period),
        .cfg_retry_period(cfg_retry_period), .probe_send(probe_send),
        .circuit_up(circuit_up)
    );

    // Driver: one cycle of stimulus plus the outputs expected after its edge.
    task automatic step(bit t, bit r, bit en, bit ep, bit eu, string req);
        exp_t e;
        @(negedge clk);
        sec_tick = t;
        reply_rx = r;
        enable   = en;
        e.probe  = ep;
        e.up     = eu;
        e.req    = req;
        q.push_back(e);
    endtask

    // n ticks; reply with the first; a probe only on the last; state changes there.
    task automatic run(int n, bit rep, bit up_before, bit up_after, string req);
        for (int i = 0; i < n; i++) begin
            step(1'b1, rep && (i == 0), 1'b1, i == n - 1,
                 (i == n - 1) ? up_after : up_before, req);
        end
    endtask

    // Monitor: compares each result shortly after the edge that produced it.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (probe_send !== e.probe || circuit_up !== e.up) begin
                n_fail++;
                $display("FAIL %s: probe/up actual %b/%b expected %b/%b",
                         e.req, probe_send, circuit_up, e.probe, e.up);
            end
        end
    end

    initial begin
        // R9: reset state
        step(0, 0, 0, 0, 1, "R9"); step(0, 0, 0, 0, 1, "R9"); step(0, 0, 0, 0, 1, "R9");
        @(negedge clk); rst_n = 1'b1;
        // R8: ticks and replies while disabled give nothing
        step(1, 0, 0, 0, 1, "R8"); step(1, 1, 0, 0, 1, "R8"); step(1, 0, 0, 0, 1, "R8");
        step(1, 0, 1, 0, 1, "R9");          // enable rise: restart, tick ignored
        run(4, 0, 1, 1, "R9");              // first probe on 4th tick
        step(0, 0, 1, 0, 1, "R10");         // no tick, no probe
        run(4, 1, 1, 1, "R3");              // answered, normal period
        run(4, 1, 1, 1, "R3");
        run(4, 0, 1, 1, "R4");              // miss 1 -> retry period
        run(1, 0, 1, 0, "R2");              // miss 2 -> down
        run(4, 0, 0, 0, "R5");              // back to normal period
        run(4, 1, 0, 0, "R4");              // answer 1 -> retry
        run(1, 0, 0, 0, "R7");              // miss clears answers -> normal
        run(4, 1, 0, 0, "R7");              // fresh answer 1
        run(1, 1, 0, 0, "R6");              // reply in due cycle counts: 2
        run(1, 1, 0, 1, "R1");              // answer 3 -> up
        run(4, 0, 1, 1, "R5");              // normal after up; miss 1
        run(1, 1, 1, 1, "R7");              // reply clears miss -> normal
        run(4, 0, 1, 1, "R3");              // normal spacing; miss 1
        run(1, 0, 1, 0, "R2");              // down
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R8");
        step(1, 0, 1, 0, 1, "R9");          // re-enable -> up
        run(4, 0, 1, 1, "R9");
        step(0, 0, 1, 0, 1, "R10");
        step(0, 0, 1, 0, 1, "R10");
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule